// File: doc/BRIEF.md
# Sharing-List Read-Miss Line Controller

This block is the coherence engine of one node in a machine whose directory is spread across the caches. Each memory line has a home node, chosen by the low bits of the line index. The home keeps only a three-valued state and a pointer to the first sharer. Every cache line that holds a copy keeps its own place in a doubly linked list of sharers, with a pointer toward the tail and a pointer toward the head. A read miss does not end at the home. The home hands back the identity of the previous first sharer. The requester then links itself in front of that node, so it becomes the new first sharer.

The same instance plays all three roles. It is the requester for misses raised by its own processor. It is the home for lines whose low index bits equal its node ID. It is the old head when another node asks to be linked in front of one of its lines. Messages enter on one port and leave on a registered port, one per cycle. Each message carries a type, source node, destination node, line index, a pointer field and a one-bit flag. An attach request that reaches a line in flight is refused with a retry. The refused requester waits a fixed number of cycles and then sends the attach again. A read-only lookup port returns the cache and home state of any line, so the local bus snoop logic and tests can observe it.

Top module: `slist_line_ctrl`

## Requirements
- R1: After reset every cache line is INVALID (state code 0) with both pointers null. Every home entry is HOME (code 0) with head 0. `out_valid` is low and `miss_rdy` is high.
- R2: A miss accepted on an INVALID line produces, one cycle later, a read request (type 0) to node `line[NODE_W-1:0]`, with flag equal to the exclusive bit. The line enters the pending-read (1) or pending-exclusive (2) state. A miss on a line that is not INVALID sends nothing and changes nothing.
- R3: A read request (type 0) for an owned line in HOME gets a data reply (type 1) with flag 0. The home moves to FRESH (1), or to GONE (2) when the request flag is set, and records the requester as head.
- R4: A read request for a FRESH owned line gets a data reply (type 1) with flag 1 and the old head in the pointer field. The head becomes the requester.
- R5: A read request for a GONE owned line gets a pointer-only reply (type 2) carrying the old head. The home stays GONE and the head becomes the requester.
- R6: A data reply with flag 0 to a pending line ends in ONLY_FRESH (5) after a plain request, or in ONLY_DIRTY (6) after an exclusive one. Both pointers become null.
- R7: A data reply with flag 1, or a pointer-only reply, to a pending line sends an attach request (type 3) to the node in the pointer field. It records that node as the forward pointer. The line enters pending-attach-fresh (3) or pending-attach-gone (4), respectively.
- R8: An attach reply (type 4) from the forward-pointer node ends in HEAD_FRESH (7) from state 3, or HEAD_DIRTY (8) from state 4. The backward pointer becomes null and the forward pointer stays on the old head.
- R9: An attach request on a line in HEAD_FRESH or HEAD_DIRTY moves it to MID_VALID (9). On a line in ONLY_FRESH or ONLY_DIRTY it moves to TAIL_VALID (10). In each case the backward pointer is set to the sender, and an attach reply goes back with flag 1 exactly when the old state was dirty.
- R10: An attach request on a line in any other state, pending ones included, is answered with a retry (type 5) and leaves the line unchanged.
- R11: A retry from the forward-pointer node to a line in state 3 or 4 makes the block resend the attach request to that node exactly BACKOFF cycles after the retry was taken.
- R12: Messages whose destination is not this node, read requests for lines owned by another home, and replies that do not match the line's state or forward pointer produce no output and change no state.
- R13: Every output message is a single-cycle pulse with source equal to `my_id`. `miss_rdy` is low whenever `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| my_id | input | NODE_W | This node's ID |
| miss_valid | input | 1 | Processor read miss request |
| miss_line | input | LINE_W | Line index of the miss |
| miss_excl | input | 1 | Miss asks for a writable copy |
| miss_rdy | output | 1 | Miss can be taken this cycle |
| in_valid | input | 1 | Incoming message present |
| in_type | input | 3 | Incoming message type |
| in_src | input | NODE_W | Sender node |
| in_dst | input | NODE_W | Destination node |
| in_line | input | LINE_W | Line index |
| in_ptr | input | NODE_W | Pointer payload |
| in_flag | input | 1 | Flag payload |
| out_valid | output | 1 | Outgoing message present |
| out_type | output | 3 | Outgoing message type |
| out_src | output | NODE_W | Sender (this node) |
| out_dst | output | NODE_W | Destination node |
| out_line | output | LINE_W | Line index |
| out_ptr | output | NODE_W | Pointer payload |
| out_flag | output | 1 | Flag payload |
| probe_line | input | LINE_W | Line to look up |
| probe_state | output | 4 | Cache state of that line |
| probe_fwd | output | NODE_W | Forward pointer |
| probe_fwd_vld | output | 1 | Forward pointer is not null |
| probe_bwd | output | NODE_W | Backward pointer |
| probe_bwd_vld | output | 1 | Backward pointer is not null |
| probe_hstate | output | 2 | Home state of that line |
| probe_head | output | NODE_W | Home head pointer |

## Verification
The checks assume that at most one message arrives per cycle, and that the processor only raises a miss while `miss_rdy` is high. They also assume that message types stay within the six defined codes and that `LINE_W` is at least `NODE_W`. The stimulus keeps to these limits. It drives one message or one miss per cycle, never both. It never sends a message to a line that this node both owns and requests. The only retries it sends come from the node the line points to.

// File: rtl/slist_pkg.sv
package slist_pkg;

  typedef enum logic [2:0] {
    MT_RD_REQ  = 3'd0,
    MT_RD_DATA = 3'd1,
    MT_RD_PTR  = 3'd2,
    MT_ATT_REQ = 3'd3,
    MT_ATT_REP = 3'd4,
    MT_RETRY   = 3'd5
  } msg_t;

  typedef enum logic [3:0] {
    CS_INV        = 4'd0,
    CS_PEND_RD    = 4'd1,
    CS_PEND_EX    = 4'd2,
    CS_PEND_ATF   = 4'd3,
    CS_PEND_ATG   = 4'd4,
    CS_ONLY_FRESH = 4'd5,
    CS_ONLY_DIRTY = 4'd6,
    CS_HEAD_FRESH = 4'd7,
    CS_HEAD_DIRTY = 4'd8,
    CS_MID_VALID  = 4'd9,
    CS_TAIL_VALID = 4'd10
  } cst_t;

  typedef enum logic [1:0] {
    HS_HOME  = 2'd0,
    HS_FRESH = 2'd1,
    HS_GONE  = 2'd2
  } hst_t;

  function automatic logic is_pend(cst_t s);
    return (s == CS_PEND_RD) || (s == CS_PEND_EX) ||
           (s == CS_PEND_ATF) || (s == CS_PEND_ATG);
  endfunction

  function automatic logic is_pend_att(cst_t s);
    return (s == CS_PEND_ATF) || (s == CS_PEND_ATG);
  endfunction

endpackage

// File: rtl/slist_home_dir.sv
module slist_home_dir
  import slist_pkg::*;
#(
  parameter int NODE_W = 2,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NODE_W-1:0] my_id,
  input  logic              req_vld,
  input  logic [NODE_W-1:0] req_src,
  input  logic [LINE_W-1:0] req_line,
  input  logic              req_excl,
  output logic              rsp_vld,
  output logic [2:0]        rsp_type,
  output logic [NODE_W-1:0] rsp_ptr,
  output logic              rsp_flag,
  input  logic [LINE_W-1:0] probe_line,
  output logic [1:0]        probe_hstate,
  output logic [NODE_W-1:0] probe_head
);

  localparam int NLINES = 1 << LINE_W;

  hst_t              hst  [NLINES];
  logic [NODE_W-1:0] head [NLINES];

  logic req_ok;
  hst_t n_hst;

  always_comb begin
    req_ok   = req_vld && (req_line[NODE_W-1:0] == my_id);
    rsp_vld  = req_ok;
    rsp_type = MT_RD_DATA;
    rsp_ptr  = head[req_line];
    rsp_flag = 1'b0;
    n_hst    = hst[req_line];
    case (hst[req_line])
      HS_HOME: begin
        rsp_ptr = '0;
        n_hst   = req_excl ? HS_GONE : HS_FRESH;
      end
      HS_FRESH: rsp_flag = 1'b1;
      default:  rsp_type = MT_RD_PTR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINES; i++) begin
        hst[i]  <= HS_HOME;
        head[i] <= '0;
      end
    end else if (req_ok) begin
      hst[req_line]  <= n_hst;
      head[req_line] <= req_src;
    end
  end

  assign probe_hstate = hst[probe_line];
  assign probe_head   = head[probe_line];

  // R3
  home_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ok && hst[req_line] == HS_HOME) |=> (hst[$past(req_line)] != HS_HOME));

  // R5
  gone_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ok && hst[req_line] == HS_GONE) |=>
      (hst[$past(req_line)] == HS_GONE && head[$past(req_line)] == $past(req_src)));

endmodule

// File: rtl/slist_backoff.sv
module slist_backoff #(
  parameter int LINE_W  = 4,
  parameter int BACKOFF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_vld,
  input  logic [LINE_W-1:0] set_line,
  input  logic              clr_vld,
  input  logic [LINE_W-1:0] clr_line,
  output logic              due_any,
  output logic [LINE_W-1:0] due_line
);

  localparam int NLINES = 1 << LINE_W;
  localparam int CW     = $clog2(BACKOFF + 1);

  logic [CW-1:0] cnt [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst)
        cnt[g] <= '0;
      else if (set_vld && set_line == LINE_W'(g))
        cnt[g] <= CW'(BACKOFF);
      else if (clr_vld && clr_line == LINE_W'(g))
        cnt[g] <= '0;
      else if (cnt[g] > CW'(1))
        cnt[g] <= cnt[g] - CW'(1);
    end
  end

  always_comb begin
    due_any  = 1'b0;
    due_line = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (cnt[i] == CW'(1)) begin
        due_any  = 1'b1;
        due_line = LINE_W'(i);
      end
    end
  end

  // R11
  clr_due_chk: assert property (@(posedge clk) disable iff (rst)
    clr_vld |-> due_any);

endmodule

// File: rtl/slist_cache_dir.sv
module slist_cache_dir
  import slist_pkg::*;
#(
  parameter int NODE_W = 2,
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NODE_W-1:0] my_id,
  input  logic              in_busy,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic              miss_excl,
  output logic              miss_rdy,
  input  logic              msg_vld,
  input  logic [2:0]        msg_type,
  input  logic [NODE_W-1:0] msg_src,
  input  logic [LINE_W-1:0] msg_line,
  input  logic [NODE_W-1:0] msg_ptr,
  input  logic              msg_flag,
  input  logic              due_any,
  input  logic [LINE_W-1:0] due_line,
  output logic              set_vld,
  output logic              clr_vld,
  output logic              rsp_vld,
  output logic [2:0]        rsp_type,
  output logic [NODE_W-1:0] rsp_dst,
  output logic [LINE_W-1:0] rsp_line,
  output logic [NODE_W-1:0] rsp_ptr,
  output logic              rsp_flag,
  input  logic [LINE_W-1:0] probe_line,
  output logic [3:0]        probe_state,
  output logic [NODE_W-1:0] probe_fwd,
  output logic              probe_fwd_vld,
  output logic [NODE_W-1:0] probe_bwd,
  output logic              probe_bwd_vld
);

  localparam int NLINES = 1 << LINE_W;

  cst_t              cst  [NLINES];
  logic [NODE_W-1:0] fwd  [NLINES];
  logic [NODE_W-1:0] bwd  [NLINES];
  logic              fwdv [NLINES];
  logic              bwdv [NLINES];

  logic              upd;
  logic [LINE_W-1:0] ul;
  cst_t              n_st;
  logic [NODE_W-1:0] n_fwd, n_bwd;
  logic              n_fwdv, n_bwdv;
  cst_t              cur;

  always_comb begin
    miss_rdy = !in_busy && !due_any;
    clr_vld  = due_any && !in_busy;
    set_vld  = 1'b0;
    rsp_vld  = 1'b0;
    rsp_type = MT_RD_REQ;
    rsp_dst  = msg_src;
    rsp_line = msg_line;
    rsp_ptr  = '0;
    rsp_flag = 1'b0;
    upd      = 1'b0;
    if (msg_vld)       ul = msg_line;
    else if (clr_vld)  ul = due_line;
    else               ul = miss_line;
    cur    = cst[ul];
    n_st   = cur;
    n_fwd  = fwd[ul];
    n_fwdv = fwdv[ul];
    n_bwd  = bwd[ul];
    n_bwdv = bwdv[ul];
    if (msg_vld) begin
      case (msg_type)
        MT_RD_DATA: begin
          if (cur == CS_PEND_RD || cur == CS_PEND_EX) begin
            upd = 1'b1;
            if (msg_flag) begin
              n_st     = CS_PEND_ATF;
              n_fwd    = msg_ptr;
              n_fwdv   = 1'b1;
              rsp_vld  = 1'b1;
              rsp_type = MT_ATT_REQ;
              rsp_dst  = msg_ptr;
            end else begin
              n_st   = (cur == CS_PEND_EX) ? CS_ONLY_DIRTY : CS_ONLY_FRESH;
              n_fwdv = 1'b0;
              n_bwdv = 1'b0;
            end
          end
        end
        MT_RD_PTR: begin
          if (cur == CS_PEND_RD || cur == CS_PEND_EX) begin
            upd      = 1'b1;
            n_st     = CS_PEND_ATG;
            n_fwd    = msg_ptr;
            n_fwdv   = 1'b1;
            rsp_vld  = 1'b1;
            rsp_type = MT_ATT_REQ;
            rsp_dst  = msg_ptr;
          end
        end
        MT_ATT_REP: begin
          if (is_pend_att(cur) && fwdv[ul] && fwd[ul] == msg_src) begin
            upd    = 1'b1;
            n_st   = (cur == CS_PEND_ATF) ? CS_HEAD_FRESH : CS_HEAD_DIRTY;
            n_bwdv = 1'b0;
          end
        end
        MT_ATT_REQ: begin
          rsp_vld = 1'b1;
          case (cur)
            CS_HEAD_FRESH, CS_HEAD_DIRTY, CS_ONLY_FRESH, CS_ONLY_DIRTY: begin
              upd      = 1'b1;
              n_st     = (cur == CS_HEAD_FRESH || cur == CS_HEAD_DIRTY) ?
                         CS_MID_VALID : CS_TAIL_VALID;
              n_bwd    = msg_src;
              n_bwdv   = 1'b1;
              rsp_type = MT_ATT_REP;
              rsp_flag = (cur == CS_HEAD_DIRTY || cur == CS_ONLY_DIRTY);
            end
            default: rsp_type = MT_RETRY;
          endcase
        end
        MT_RETRY: begin
          if (is_pend_att(cur) && fwdv[ul] && fwd[ul] == msg_src)
            set_vld = 1'b1;
        end
        default: ;
      endcase
    end else if (clr_vld) begin
      if (is_pend_att(cur)) begin
        rsp_vld  = 1'b1;
        rsp_type = MT_ATT_REQ;
        rsp_dst  = fwd[ul];
        rsp_line = ul;
      end
    end else if (miss_valid && miss_rdy && cur == CS_INV) begin
      upd      = 1'b1;
      n_st     = miss_excl ? CS_PEND_EX : CS_PEND_RD;
      n_fwdv   = 1'b0;
      n_bwdv   = 1'b0;
      rsp_vld  = 1'b1;
      rsp_type = MT_RD_REQ;
      rsp_dst  = miss_line[NODE_W-1:0];
      rsp_line = miss_line;
      rsp_flag = miss_excl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINES; i++) begin
        cst[i]  <= CS_INV;
        fwd[i]  <= '0;
        bwd[i]  <= '0;
        fwdv[i] <= 1'b0;
        bwdv[i] <= 1'b0;
      end
    end else if (upd) begin
      cst[ul]  <= n_st;
      fwd[ul]  <= n_fwd;
      bwd[ul]  <= n_bwd;
      fwdv[ul] <= n_fwdv;
      bwdv[ul] <= n_bwdv;
    end
  end

  assign probe_state   = cst[probe_line];
  assign probe_fwd     = fwd[probe_line];
  assign probe_fwd_vld = fwdv[probe_line];
  assign probe_bwd     = bwd[probe_line];
  assign probe_bwd_vld = bwdv[probe_line];

  logic unused_id;
  assign unused_id = ^my_id;

  // R10
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_vld && msg_type == MT_ATT_REQ && is_pend(cst[msg_line])) |=>
      (cst[$past(msg_line)] == $past(cst[msg_line])));

  // R9
  only_to_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_vld && msg_type == MT_ATT_REQ && cst[msg_line] == CS_ONLY_FRESH) |=>
      (cst[$past(msg_line)] == CS_TAIL_VALID && bwdv[$past(msg_line)]));

endmodule

// File: rtl/slist_line_ctrl.sv
module slist_line_ctrl
  import slist_pkg::*;
#(
  parameter int NODE_W  = 2,
  parameter int LINE_W  = 4,
  parameter int BACKOFF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NODE_W-1:0] my_id,
  input  logic              miss_valid,
  input  logic [LINE_W-1:0] miss_line,
  input  logic              miss_excl,
  output logic              miss_rdy,
  input  logic              in_valid,
  input  logic [2:0]        in_type,
  input  logic [NODE_W-1:0] in_src,
  input  logic [NODE_W-1:0] in_dst,
  input  logic [LINE_W-1:0] in_line,
  input  logic [NODE_W-1:0] in_ptr,
  input  logic              in_flag,
  output logic              out_valid,
  output logic [2:0]        out_type,
  output logic [NODE_W-1:0] out_src,
  output logic [NODE_W-1:0] out_dst,
  output logic [LINE_W-1:0] out_line,
  output logic [NODE_W-1:0] out_ptr,
  output logic              out_flag,
  input  logic [LINE_W-1:0] probe_line,
  output logic [3:0]        probe_state,
  output logic [NODE_W-1:0] probe_fwd,
  output logic              probe_fwd_vld,
  output logic [NODE_W-1:0] probe_bwd,
  output logic              probe_bwd_vld,
  output logic [1:0]        probe_hstate,
  output logic [NODE_W-1:0] probe_head
);

  logic for_me, home_req, cache_msg;
  assign for_me    = in_valid && (in_dst == my_id);
  assign home_req  = for_me && (in_type == MT_RD_REQ);
  assign cache_msg = for_me && (in_type != MT_RD_REQ);

  logic              h_vld, h_flag;
  logic [2:0]        h_type;
  logic [NODE_W-1:0] h_ptr;

  slist_home_dir #(.NODE_W(NODE_W), .LINE_W(LINE_W)) u_home (
    .clk(clk), .rst(rst), .my_id(my_id),
    .req_vld(home_req), .req_src(in_src), .req_line(in_line), .req_excl(in_flag),
    .rsp_vld(h_vld), .rsp_type(h_type), .rsp_ptr(h_ptr), .rsp_flag(h_flag),
    .probe_line(probe_line), .probe_hstate(probe_hstate), .probe_head(probe_head)
  );

  logic              set_vld, clr_vld, due_any;
  logic [LINE_W-1:0] due_line;

  slist_backoff #(.LINE_W(LINE_W), .BACKOFF(BACKOFF)) u_backoff (
    .clk(clk), .rst(rst),
    .set_vld(set_vld), .set_line(in_line),
    .clr_vld(clr_vld), .clr_line(due_line),
    .due_any(due_any), .due_line(due_line)
  );

  logic              c_vld, c_flag;
  logic [2:0]        c_type;
  logic [NODE_W-1:0] c_dst, c_ptr;
  logic [LINE_W-1:0] c_line;

  slist_cache_dir #(.NODE_W(NODE_W), .LINE_W(LINE_W)) u_cache (
    .clk(clk), .rst(rst), .my_id(my_id), .in_busy(in_valid),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_excl(miss_excl),
    .miss_rdy(miss_rdy),
    .msg_vld(cache_msg), .msg_type(in_type), .msg_src(in_src), .msg_line(in_line),
    .msg_ptr(in_ptr), .msg_flag(in_flag),
    .due_any(due_any), .due_line(due_line),
    .set_vld(set_vld), .clr_vld(clr_vld),
    .rsp_vld(c_vld), .rsp_type(c_type), .rsp_dst(c_dst), .rsp_line(c_line),
    .rsp_ptr(c_ptr), .rsp_flag(c_flag),
    .probe_line(probe_line), .probe_state(probe_state),
    .probe_fwd(probe_fwd), .probe_fwd_vld(probe_fwd_vld),
    .probe_bwd(probe_bwd), .probe_bwd_vld(probe_bwd_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_type  <= '0;
      out_src   <= '0;
      out_dst   <= '0;
      out_line  <= '0;
      out_ptr   <= '0;
      out_flag  <= 1'b0;
    end else begin
      out_valid <= h_vld || c_vld;
      out_src   <= my_id;
      if (h_vld) begin
        out_type <= h_type;
        out_dst  <= in_src;
        out_line <= in_line;
        out_ptr  <= h_ptr;
        out_flag <= h_flag;
      end else begin
        out_type <= c_type;
        out_dst  <= c_dst;
        out_line <= c_line;
        out_ptr  <= c_ptr;
        out_flag <= c_flag;
      end
    end
  end

  // R13
  legal_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_type <= 3'd5 && out_src == $past(my_id)));

endmodule

// File: tb/slist_line_ctrl_test.sv
module slist_line_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 2;
  localparam int LW = 4;
  localparam int BO = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] my_id = 2'd1;
  logic          miss_valid = 1'b0, miss_excl = 1'b0;
  logic [LW-1:0] miss_line = '0;
  logic          miss_rdy;
  logic          in_valid = 1'b0, in_flag = 1'b0;
  logic [2:0]    in_type = '0;
  logic [NW-1:0] in_src = '0, in_dst = '0, in_ptr = '0;
  logic [LW-1:0] in_line = '0;
  logic          out_valid, out_flag;
  logic [2:0]    out_type;
  logic [NW-1:0] out_src, out_dst, out_ptr;
  logic [LW-1:0] out_line;
  logic [LW-1:0] probe_line = '0;
  logic [3:0]    probe_state;
  logic [NW-1:0] probe_fwd, probe_bwd, probe_head;
  logic          probe_fwd_vld, probe_bwd_vld;
  logic [1:0]    probe_hstate;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slist_line_ctrl #(.NODE_W(NW), .LINE_W(LW), .BACKOFF(BO)) uut (
    .clk(clk), .rst(rst), .my_id(my_id),
    .miss_valid(miss_valid), .miss_line(miss_line), .miss_excl(miss_excl),
    .miss_rdy(miss_rdy),
    .in_valid(in_valid), .in_type(in_type), .in_src(in_src), .in_dst(in_dst),
    .in_line(in_line), .in_ptr(in_ptr), .in_flag(in_flag),
    .out_valid(out_valid), .out_type(out_type), .out_src(out_src), .out_dst(out_dst),
    .out_line(out_line), .out_ptr(out_ptr), .out_flag(out_flag),
    .probe_line(probe_line), .probe_state(probe_state),
    .probe_fwd(probe_fwd), .probe_fwd_vld(probe_fwd_vld),
    .probe_bwd(probe_bwd), .probe_bwd_vld(probe_bwd_vld),
    .probe_hstate(probe_hstate), .probe_head(probe_head)
  );

  typedef struct packed {
    logic          is_miss;
    logic          flag;
    logic [2:0]    typ;
    logic [NW-1:0] src;
    logic [NW-1:0] dst;
    logic [LW-1:0] line;
    logic [NW-1:0] ptr;
    logic          e_ov;
    logic [2:0]    e_typ;
    logic [NW-1:0] e_dst;
    logic [NW-1:0] e_ptr;
    logic          e_flag;
    logic [3:0]    e_cst;
    logic [1:0]    e_hs;
    logic [NW-1:0] e_head;
  } vec_t;

  localparam int NV = 24;
  // Fields: is_miss, flag, type, src, dst, line, ptr | out valid, type, dst, ptr, flag | cache st, home st, head
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,3'd0,2'd0,2'd0,4'd2, 2'd0, 1'b1,3'd0,2'd2,2'd0,1'b0, 4'd1, 2'd0,2'd0}, // R2
    '{1'b0,1'b0,3'd1,2'd2,2'd1,4'd2, 2'd0, 1'b0,3'd0,2'd0,2'd0,1'b0, 4'd5, 2'd0,2'd0}, // R6
    '{1'b0,1'b0,3'd3,2'd3,2'd1,4'd2, 2'd0, 1'b1,3'd4,2'd3,2'd0,1'b0, 4'd10,2'd0,2'd0}, // R9
    '{1'b1,1'b0,3'd0,2'd0,2'd0,4'd2, 2'd0, 1'b0,3'd0,2'd0,2'd0,1'b0, 4'd10,2'd0,2'd0}, // R2
    '{1'b1,1'b0,3'd0,2'd0,2'd0,4'd6, 2'd0, 1'b1,3'd0,2'd2,2'd0,1'b0, 4'd1, 2'd0,2'd0}, // R2
    '{1'b0,1'b1,3'd1,2'd2,2'd1,4'd6, 2'd3, 1'b1,3'd3,2'd3,2'd0,1'b0, 4'd3, 2'd0,2'd0}, // R7
    '{1'b0,1'b0,3'd4,2'd0,2'd1,4'd6, 2'd0, 1'b0,3'd0,2'd0,2'd0,1'b0, 4'd3, 2'd0,2'd0}, // R12
    '{1'b0,1'b0,3'd4,2'd3,2'd1,4'd6, 2'd0, 1'b0,3'd0,2'd0,2'd0,1'b0, 4'd7, 2'd0,2'd0}, // R8
    '{1'b0,1'b0,3'd3,2'd0,2'd1,4'd6, 2'd0, 1'b1,3'd4,2'd0,2'd0,1'b0, 4'd9, 2'd0,2'd0}, // R9
    '{1'b1,1'b1,3'd0,2'd0,2'd0,4'd3, 2'd0, 1'b1,3'd0,2'd3,2'd0,1'b1, 4'd2, 2'd0,2'd0}, // R2
    '{1'b0,1'b0,3'd1,2'd3,2'd1,4'd3, 2'd0, 1'b0,3'd0,2'd0,2'd0,1'b0, 4'd6, 2'd0,2'd0}, // R6
    '{1'b0,1'b0,3'd3,2'd2,2'd1,4'd3, 2'd0, 1'b1,3'd4,2'd2,2'd0,1'b1, 4'd10,2'd0,2'd0}, // R9
    '{1'b0,1'b0,3'd0,2'd3,2'd1,4'd5, 2'd0, 1'b1,3'd1,2'd3,2'd0,1'b0, 4'd0, 2'd1,2'd3}, // R3
    '{1'b0,1'b0,3'd0,2'd2,2'd1,4'd5, 2'd0, 1'b1,3'd1,2'd2,2'd3,1'b1, 4'd0, 2'd1,2'd2}, // R4
    '{1'b0,1'b1,3'd0,2'd3,2'd1,4'd9, 2'd0, 1'b1,3'd1,2'd3,2'd0,1'b0, 4'd0, 2'd2,2'd3}, // R3
    '{1'b0,1'b0,3'd0,2'd0,2'd1,4'd9, 2'd0, 1'b1,3'd2,2'd0,2'd3,1'b0, 4'd0, 2'd2,2'd0}, // R5
    '{1'b0,1'b0,3'd0,2'd0,2'd1,4'd6, 2'd0, 1'b0,3'd0,2'd0,2'd0,1'b0, 4'd9, 2'd0,2'd0}, // R12
    '{1'b0,1'b0,3'd3,2'd3,2'd2,4'd6, 2'd0, 1'b0,3'd0,2'd0,2'd0,1'b0, 4'd9, 2'd0,2'd0}, // R12
    '{1'b1,1'b0,3'd0,2'd0,2'd0,4'd7, 2'd0, 1'b1,3'd0,2'd3,2'd0,1'b0, 4'd1, 2'd0,2'd0}, // R2
    '{1'b0,1'b0,3'd2,2'd3,2'd1,4'd7, 2'd0, 1'b1,3'd3,2'd0,2'd0,1'b0, 4'd4, 2'd0,2'd0}, // R7
    '{1'b0,1'b0,3'd3,2'd2,2'd1,4'd7, 2'd0, 1'b1,3'd5,2'd2,2'd0,1'b0, 4'd4, 2'd0,2'd0}, // R10
    '{1'b0,1'b1,3'd4,2'd0,2'd1,4'd7, 2'd0, 1'b0,3'd0,2'd0,2'd0,1'b0, 4'd8, 2'd0,2'd0}, // R8
    '{1'b0,1'b0,3'd3,2'd2,2'd1,4'd7, 2'd0, 1'b1,3'd4,2'd2,2'd0,1'b1, 4'd9, 2'd0,2'd0}, // R9
    '{1'b0,1'b0,3'd3,2'd0,2'd1,4'd0, 2'd0, 1'b1,3'd5,2'd0,2'd0,1'b0, 4'd0, 2'd0,2'd0}  // R10
  };

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    miss_valid = 1'b0;
    in_valid   = 1'b0;
  endtask

  task automatic send(input logic [2:0] t, input logic [NW-1:0] s, input logic [NW-1:0] d,
                      input logic [LW-1:0] l, input logic [NW-1:0] p, input logic f);
    in_valid = 1'b1; in_type = t; in_src = s; in_dst = d;
    in_line = l; in_ptr = p; in_flag = f;
  endtask

  task automatic miss(input logic [LW-1:0] l, input logic x);
    miss_valid = 1'b1; miss_line = l; miss_excl = x;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int waited;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    probe_line = 4'd5;
    #1;
    check("R1 out_valid", out_valid, 0);
    check("R1 cache state", probe_state, 0);
    check("R1 home state", probe_hstate, 0);
    check("R1 fwd null", probe_fwd_vld, 0);
    check("R1 miss_rdy", miss_rdy, 1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      if (VEC[i].is_miss) miss(VEC[i].line, VEC[i].flag);
      else send(VEC[i].typ, VEC[i].src, VEC[i].dst, VEC[i].line, VEC[i].ptr, VEC[i].flag);
      probe_line = VEC[i].line;
      @(negedge clk);
      idle();
      check($sformatf("vec %0d out_valid", i), out_valid, VEC[i].e_ov);
      if (VEC[i].e_ov) begin
        check($sformatf("vec %0d out_type", i), out_type, VEC[i].e_typ);
        check($sformatf("vec %0d out_dst", i), out_dst, VEC[i].e_dst);
        check($sformatf("vec %0d out_ptr", i), out_ptr, VEC[i].e_ptr);
        check($sformatf("vec %0d out_flag", i), out_flag, VEC[i].e_flag);
        check($sformatf("vec %0d out_line", i), out_line, VEC[i].line);
        check($sformatf("vec %0d R13 out_src", i), out_src, my_id);
      end
      check($sformatf("vec %0d cache state", i), probe_state, VEC[i].e_cst);
      check($sformatf("vec %0d home state", i), probe_hstate, VEC[i].e_hs);
      check($sformatf("vec %0d home head", i), probe_head, VEC[i].e_head);
    end

    // R13 single-cycle pulse
    @(negedge clk);
    check("R13 pulse ends", out_valid, 0);

    // R9 old head backward pointer (line 2 taken by node 3)
    probe_line = 4'd2;
    #1;
    check("R9 bwd ptr", probe_bwd, 3);
    check("R9 bwd valid", probe_bwd_vld, 1);

    // R13 miss_rdy low while a message is present
    send(3'd3, 2'd0, 2'd2, 4'd11, 2'd0, 1'b0);
    miss(4'd11, 1'b0);
    #1;
    check("R13 miss_rdy busy", miss_rdy, 0);
    @(negedge clk);
    idle();
    probe_line = 4'd11;
    #1;
    check("R13 no take while busy", probe_state, 0);
    check("R12 foreign dst no out", out_valid, 0);

    // R11 retry backoff on line 10 (home node 2), old head node 3
    @(negedge clk);
    miss(4'd10, 1'b0);
    @(negedge clk);
    idle();
    send(3'd1, 2'd2, 2'd1, 4'd10, 2'd3, 1'b1);
    @(negedge clk);
    idle();
    check("R7 attach sent", out_type, 3);
    send(3'd5, 2'd3, 2'd1, 4'd10, 2'd0, 1'b0);
    @(negedge clk);
    idle();
    check("R11 no output on retry", out_valid, 0);
    waited = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      waited++;
      if (out_valid) break;
    end
    check("R11 resend delay", waited, BO);
    check("R11 resend type", out_type, 3);
    check("R11 resend dst", out_dst, 3);
    check("R11 resend line", out_line, 10);

    // R8 finish attach, check pointers
    send(3'd4, 2'd3, 2'd1, 4'd10, 2'd0, 1'b0);
    @(negedge clk);
    idle();
    probe_line = 4'd10;
    #1;
    check("R8 head fresh", probe_state, 7);
    check("R8 fwd ptr", probe_fwd, 3);
    check("R8 fwd valid", probe_fwd_vld, 1);
    check("R8 bwd null", probe_bwd_vld, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule